// File: doc/BRIEF.md
# UART Receive Character Time-out Detector

This block watches the occupancy of a UART receive FIFO and raises a pending time-out flag when characters sit in the FIFO without being serviced. The flag feeds the interrupt identification logic. The receiver shift logic, the FIFO storage and interrupt prioritisation are outside this block. A counter advances on receive clock-enable ticks while the FIFO holds data. It restarts whenever a character is pushed into or popped from the FIFO.

The length of the wait is not fixed. It is recomputed from the programmed word length, the trigger level and the current character count, which gives roughly three and a half to four and a half character times. A shorter FIFO backlog relative to the trigger level lengthens the wait. A full or over-trigger FIFO uses the base length. A read of the receive buffer clears the flag. A FIFO reset clears both the flag and the counter.

Top module: `uart_rx_tmo_det`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the time-out flag reads 0.
- R2: The target length in ticks is ((W*7)-2)*8 + (D*8+1). W is the word length, with code 0,1,2,3 on the word-length input meaning 5,6,7,8 bits. D is trigger level minus character count when the count is below the trigger level, and 0 otherwise. With 8 bits, trigger 4 and count 1 the target is 457. With 5 bits, trigger 2 and count 6 it is 265.
- R3: The counter advances only in cycles where the tick input is 1. The flag becomes 1 in the cycle after the clock edge that carries the target-th tick counted since the last restart.
- R4: While the character count is 0 the counter is held at zero and the flag is never raised by counting.
- R5: A push or pop strobe restarts the period. A tick in the same cycle as the strobe is not counted.
- R6: A receive-buffer read clears the flag at the next edge. A read in the same cycle as the final tick wins, and the flag stays 0.
- R7: Once set, the flag stays 1 until it is cleared, even if the FIFO empties or characters are pushed.
- R8: A FIFO reset clears the flag and restarts the counter at the next edge. It takes priority over every other input.
- R9: The target follows changes of trigger level or count at once. If the counter already meets a lowered target, the next tick raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rst | input | 1 | Receive FIFO reset strobe |
| rclk_tick | input | 1 | Receive clock-enable tick |
| word_len | input | 2 | Word length code (0..3 = 5..8 bits) |
| trig_lvl | input | CNT_W | FIFO trigger level in characters |
| char_cnt | input | CNT_W | Current FIFO character count |
| push | input | 1 | A character entered the FIFO |
| pop | input | 1 | A character left the FIFO |
| rbr_rd | input | 1 | Receive buffer read strobe |
| tmo_pend | output | 1 | Character time-out pending |

## Verification
The only output is registered, so every effect of a stimulus is due one edge after the cycle that carries it. This holds for the final tick, a clearing read and a FIFO reset alike. The bench drives its inputs on the falling edge. A behavioural model updates on the same rising edge as the design, and the flag is compared at every falling edge, which is half a period after it settles. The directed checks count ticks from the edge after a restart. They sample one tick before and at the exact tick where the flag is due, and at the falling edge right after a clearing strobe.

// File: rtl/uart_tmo_pkg.sv
package uart_tmo_pkg;

   typedef enum logic [1:0] {
      WLEN_5 = 2'd0,
      WLEN_6 = 2'd1,
      WLEN_7 = 2'd2,
      WLEN_8 = 2'd3
   } wlen_e;

   localparam int unsigned MIN_WLEN   = 5;
   localparam int unsigned MAX_WLEN   = 8;
   localparam int unsigned TICKS_CHAR = 8;

   // base ticks for a given word length in bits
   function automatic int unsigned base_ticks(input int unsigned bits);
      return (bits * 7 - 2) * TICKS_CHAR;
   endfunction

   // largest possible target for a FIFO count field of cnt_w bits
   function automatic int unsigned max_target(input int unsigned cnt_w);
      return base_ticks(MAX_WLEN) + ((1 << cnt_w) - 1) * TICKS_CHAR + 1;
   endfunction

endpackage

// File: rtl/tmo_target_calc.sv
module tmo_target_calc
   import uart_tmo_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int TMO_W      = 10,
   parameter bit BASE_TABLE = 1'b0
) (
   input  logic [1:0]       word_len,
   input  logic [CNT_W-1:0] trig_lvl,
   input  logic [CNT_W-1:0] char_cnt,
   output logic [TMO_W-1:0] target
);

   localparam int SHIFT = $clog2(TICKS_CHAR);

   logic [TMO_W-1:0] base;
   logic [CNT_W-1:0] deficit;
   logic [TMO_W-1:0] occ_term;

   generate
      if (BASE_TABLE) begin : g_table
         always_comb begin
            unique case (wlen_e'(word_len))
               WLEN_5:  base = TMO_W'(base_ticks(5));
               WLEN_6:  base = TMO_W'(base_ticks(6));
               WLEN_7:  base = TMO_W'(base_ticks(7));
               default: base = TMO_W'(base_ticks(8));
            endcase
         end
      end else begin : g_arith
         logic [TMO_W-1:0] bits;
         always_comb begin
            bits = TMO_W'(word_len) + TMO_W'(MIN_WLEN);
            base = ((bits << 3) - bits - TMO_W'(2)) << SHIFT;
         end
      end
   endgenerate

   always_comb begin
      deficit  = (trig_lvl > char_cnt) ? (trig_lvl - char_cnt) : '0;
      occ_term = (TMO_W'(deficit) << SHIFT) + TMO_W'(1);
      target   = base + occ_term;
   end

endmodule

// File: rtl/tmo_arm_ctrl.sv
module tmo_arm_ctrl #(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] char_cnt,
   input  logic             push,
   input  logic             pop,
   input  logic             fifo_rst,
   output logic             restart
);

   logic empty;

   always_comb begin
      empty   = (char_cnt == '0);
      restart = fifo_rst | push | pop | empty;
   end

endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
   parameter int TMO_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [TMO_W-1:0] target,
   output logic [TMO_W-1:0] count,
   output logic             hit
);

   logic [TMO_W:0] next_val;
   logic           reached;

   always_comb begin
      next_val = {1'b0, count} + {{TMO_W{1'b0}}, 1'b1};
      reached  = (next_val >= {1'b0, target});
      hit      = tick & ~restart & reached;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= '0;
      else if (tick && !reached)
         count <= next_val[TMO_W-1:0];
   end

   // R3
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(count));

endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_rst,
   input  logic hit,
   input  logic rbr_rd,
   output logic pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (fifo_rst || rbr_rd)
         pend <= 1'b0;
      else if (hit)
         pend <= 1'b1;
   end

   // R6
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_rd |=> !pend);
   // R7
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rbr_rd && !fifo_rst) |=> pend);
   // R8
   fifo_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> !pend);

endmodule

// File: rtl/uart_rx_tmo_det.sv
module uart_rx_tmo_det
   import uart_tmo_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter bit BASE_TABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_rst,
   input  logic             rclk_tick,
   input  logic [1:0]       word_len,
   input  logic [CNT_W-1:0] trig_lvl,
   input  logic [CNT_W-1:0] char_cnt,
   input  logic             push,
   input  logic             pop,
   input  logic             rbr_rd,
   output logic             tmo_pend
);

   localparam int unsigned TMO_MAX = max_target(CNT_W);
   localparam int          TMO_W   = $clog2(TMO_MAX + 1);

   generate
      if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt_w
         $error("uart_rx_tmo_det: CNT_W must lie in 1..12");
      end
   endgenerate

   logic             restart;
   logic [TMO_W-1:0] target;
   logic [TMO_W-1:0] count;
   logic             hit;

   tmo_target_calc #(
      .CNT_W      (CNT_W),
      .TMO_W      (TMO_W),
      .BASE_TABLE (BASE_TABLE)
   ) u_target (
      .word_len (word_len),
      .trig_lvl (trig_lvl),
      .char_cnt (char_cnt),
      .target   (target)
   );

   tmo_arm_ctrl #(
      .CNT_W (CNT_W)
   ) u_arm (
      .char_cnt (char_cnt),
      .push     (push),
      .pop      (pop),
      .fifo_rst (fifo_rst),
      .restart  (restart)
   );

   tmo_counter #(
      .TMO_W (TMO_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (rclk_tick),
      .target  (target),
      .count   (count),
      .hit     (hit)
   );

   tmo_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_rst (fifo_rst),
      .hit      (hit),
      .rbr_rd   (rbr_rd),
      .pend     (tmo_pend)
   );

   // R4
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_cnt == '0) |=> (count == '0));
   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push || pop) |=> (count == '0));
   // R2
   target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (target > TMO_W'(base_ticks(MIN_WLEN))) && (target <= TMO_W'(TMO_MAX)));
   // R3
   rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_pend) |-> $past(rclk_tick));

endmodule

// File: tb/tb_uart_rx_tmo_det.sv
module tb_uart_rx_tmo_det;

   localparam int CNT_W = 5;
   localparam int WATCHDOG = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fifo_rst = 1'b0;
   logic             rclk_tick = 1'b0;
   logic [1:0]       word_len = 2'd3;
   logic [CNT_W-1:0] trig_lvl = '0;
   logic [CNT_W-1:0] char_cnt = '0;
   logic             push = 1'b0;
   logic             pop = 1'b0;
   logic             rbr_rd = 1'b0;
   logic             tmo_pend;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int tick_div = 1;
   int div_cnt = 0;
   bit done = 1'b0;

   // reference model state
   int m_cnt = 0;
   bit m_pend = 1'b0;

   always #2.5 clk = ~clk;

   uart_rx_tmo_det #(.CNT_W(CNT_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_rst  (fifo_rst),
      .rclk_tick (rclk_tick),
      .word_len  (word_len),
      .trig_lvl  (trig_lvl),
      .char_cnt  (char_cnt),
      .push      (push),
      .pop       (pop),
      .rbr_rd    (rbr_rd),
      .tmo_pend  (tmo_pend)
   );

   function automatic int ref_target(input int wl_code, input int trig, input int cnt);
      int bits = wl_code + 5;
      int d = (trig > cnt) ? trig - cnt : 0;
      return (bits * 7 - 2) * 8 + d * 8 + 1;
   endfunction

   // tick generator, driven on the falling edge
   always @(negedge clk) begin
      if (div_cnt + 1 >= tick_div) begin
         div_cnt   <= 0;
         rclk_tick <= 1'b1;
      end else begin
         div_cnt   <= div_cnt + 1;
         rclk_tick <= 1'b0;
      end
   end

   // behavioural reference, advanced on the rising edge
   always @(posedge clk) begin
      bit h;
      h = 1'b0;
      if (!rst_n) begin
         m_cnt  = 0;
         m_pend = 1'b0;
      end else begin
         if (fifo_rst || push || pop || char_cnt == 0)
            m_cnt = 0;
         else if (rclk_tick) begin
            if (m_cnt + 1 >= ref_target(word_len, trig_lvl, char_cnt)) h = 1'b1;
            else m_cnt = m_cnt + 1;
         end
         if (fifo_rst || rbr_rd) m_pend = 1'b0;
         else if (h) m_pend = 1'b1;
      end
   end

   task automatic check(input bit exp, input string tag);
      checks++;
      if (tmo_pend !== exp) begin
         fails++;
         $display("FAIL %s: tmo_pend=%0b expected=%0b at cycle %0d", tag, tmo_pend, exp, cycles);
      end
   endtask

   // per-cycle comparison against the model (R3 timing)
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) check(m_pend, "R3 model");
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe_push();
      push = 1'b1; @(negedge clk); push = 1'b0;
   endtask

   task automatic strobe_pop();
      pop = 1'b1; @(negedge clk); pop = 1'b0;
   endtask

   task automatic strobe_read();
      rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0;
   endtask

   task automatic strobe_fifo_rst();
      fifo_rst = 1'b1; @(negedge clk); fifo_rst = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
         summary();
      end
   end

   initial begin
      int p;
      wait_cyc(3);
      check(1'b0, "R1 in reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, "R1 after reset");

      // R4: empty FIFO never times out
      char_cnt = 0; trig_lvl = 1;
      wait_cyc(1000);
      check(1'b0, "R4 empty FIFO");

      // R3/R2: 8 bits, trigger 1, count 1 -> 433 ticks
      word_len = 2'd3; trig_lvl = 1; char_cnt = 1;
      p = ref_target(3, 1, 1);
      if (p != 433) begin checks++; fails++; $display("FAIL R2 ref target=%0d expected=433", p); end
      strobe_push();
      wait_cyc(p - 1);
      check(1'b0, "R3 one tick before target");
      wait_cyc(1);
      check(1'b1, "R3 at target tick");

      // R7: stays set when FIFO empties and a push arrives
      char_cnt = 0; wait_cyc(5); strobe_push(); wait_cyc(20);
      check(1'b1, "R7 sticky flag");
      // R6: read clears
      strobe_read();
      check(1'b0, "R6 read clears");

      // R2: occupancy term, 8 bits trigger 4 count 1 -> 457
      trig_lvl = 4; char_cnt = 1; strobe_push();
      wait_cyc(456);
      check(1'b0, "R2 occupancy before 457");
      wait_cyc(1);
      check(1'b1, "R2 occupancy at 457");
      // R8: fifo reset clears
      char_cnt = 0; strobe_fifo_rst();
      check(1'b0, "R8 fifo reset clears");

      // R2: 5 bits, count above trigger -> 265
      word_len = 2'd0; trig_lvl = 2; char_cnt = 6; strobe_push();
      wait_cyc(264);
      check(1'b0, "R2 base before 265");
      wait_cyc(1);
      check(1'b1, "R2 base at 265");
      char_cnt = 0; strobe_read();

      // R5: pop restarts the period
      trig_lvl = 1; char_cnt = 1; strobe_push();
      wait_cyc(200);
      strobe_pop();
      wait_cyc(264);
      check(1'b0, "R5 restart after pop");
      wait_cyc(1);
      check(1'b1, "R5 full period after pop");
      char_cnt = 0; strobe_read();

      // R6: read on the final tick wins
      char_cnt = 1; strobe_push();
      wait_cyc(264);
      rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0; char_cnt = 0;
      check(1'b0, "R6 read beats final tick");
      wait_cyc(3);
      check(1'b0, "R6 stays clear");

      // R9: lowered trigger level takes effect at once
      trig_lvl = 8; char_cnt = 1; strobe_push();
      wait_cyc(280);
      check(1'b0, "R9 below raised target");
      trig_lvl = 1;
      wait_cyc(1);
      check(1'b1, "R9 lowered target hits");
      char_cnt = 0; strobe_read();

      // R3: slow ticks, one every 4 cycles
      tick_div = 4; word_len = 2'd1; trig_lvl = 1; char_cnt = 1;
      wait_cyc(4);
      strobe_push();
      p = ref_target(1, 1, 1);
      wait_cyc((p - 2) * 4);
      check(1'b0, "R3 slow ticks early");
      wait_cyc(12);
      check(1'b1, "R3 slow ticks late");
      char_cnt = 0; strobe_fifo_rst();
      wait_cyc(4);

      done = 1'b1;
      summary();
   end

endmodule